// File: doc/BRIEF.md
# MCU Reset Sequencer

This block produces the single active-low system reset of a small microcontroller. Four sources feed it: a power-on reset input that also serves as the block's own asynchronous reset, the output of a supply brown-out comparator, an active-low external reset pin, and a one-cycle strobe from the CPU decoder that flags an undefined opcode. The comparator output and the external pin are asynchronous and each passes through a two-flop synchroniser. The undefined-opcode strobe is already in the clock domain.

After power-on, a sequencer steps through a fixed start-up wait, a boot phase that lasts until the configuration loader reports completion, and an optional power-up timer. Only then does it reach the run state. A brown-out must last a minimum number of cycles before it counts. It holds the chip in reset for as long as the supply stays low. A brown-out or an undefined opcode sends the sequencer back to the power-up timer and skips the start-up wait. A two-bit power control register holds sticky active-low flags for power-on and brown-out. Software sets them by writing ones and later reads them to learn what caused the last reset.

All interfaces are plain control and status pins. None carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `mcu_reset_seq`

## Requirements
- R1: Brown-out detection acts only while `bor_cfg_i` equals 2'b00. With any other value, a supply-low indication of any length leaves the reset and the flags untouched.
- R2: A supply-low indication held for fewer than TBOR_CYC consecutive synchronised cycles causes no reset and leaves flag bit 0 unchanged.
- R3: A supply-low indication held for TBOR_CYC cycles or more pulls `sys_rst_n_o` low and keeps it low while the indication lasts. When `bor_low_i` clears with the power-up timer enabled, reset stays low for exactly PWRT_CYC+2 more sampled cycles (two synchroniser stages plus the filter clear) and then releases.
- R4: An undefined-opcode strobe in the run state pulls `sys_rst_n_o` low in the same cycle. The next state is the power-up timer (code 2), and the register flags are not changed.
- R5: After `por_n_i` rises, the sequencer stays in the start-up wait for exactly POR_CYC cycles and then enters boot with `boot_en_o` high. It stays in boot until `boot_done_i` is seen.
- R6: With `pwrt_en_i` high, the power-up timer state lasts exactly PWRT_CYC cycles before run. With it low, boot goes straight to run, and a restart spends a single cycle in the timer state.
- R7: A low level on `ext_rst_n_i` reaches `sys_rst_n_o` after two clock edges and holds it low. The sequencer stays in run. Two edges after the pin returns high, the reset releases with no timer.
- R8: Register bit 1 is the power-on flag. It reads 0 while and after `por_n_i` is low. A write with data bit 1 set makes it 1. No other source changes it.
- R9: Register bit 0 is the brown-out flag. A qualified brown-out clears it. A write with data bit 0 set makes it 1. Power-on, the external pin and undefined opcodes leave it as it was.
- R10: Writing 0 to a register bit has no effect. Only hardware events clear the flags.
- R11: `state_o` encodes start-up wait=0, boot=1, timer=2, run=3. `sys_rst_n_o` is high only in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous; resets the block |
| bor_low_i | input | 1 | Comparator flag: supply below the brown-out level (asynchronous) |
| bor_cfg_i | input | 2 | Brown-out configuration; 2'b00 enables detection |
| ext_rst_n_i | input | 1 | External reset pin, active low (asynchronous) |
| illegal_op_i | input | 1 | One-cycle strobe: undefined opcode fetched |
| boot_done_i | input | 1 | Configuration loader finished |
| pwrt_en_i | input | 1 | Enables the power-up timer stage |
| pcon_wr_i | input | 1 | Write strobe for the power control register |
| pcon_wdata_i | input | 2 | Write data; a 1 sets the matching flag |
| pcon_rdata_o | output | 2 | Flags: bit 1 power-on (active low), bit 0 brown-out (active low) |
| boot_en_o | output | 1 | High during the boot phase |
| state_o | output | 2 | Sequencer state code |
| sys_rst_n_o | output | 1 | System reset, active low |

## Verification
Brown-out pulses are driven with lengths one below, equal to and well above the filter threshold, and with every configuration code. These separate an off-by-one in the duration filter, a wrong enable decode and a wrong release latency. A seeded random loop draws the pulse length and the configuration together and predicts trip or no trip from the two. Directed sequences drive the external pin, the opcode strobe with the timer on and off, and a second power-on. These show whether each source routes to the right stage, skips the start-up wait, and leaves or clears the right flag.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    SEQ_POR_WAIT = 2'd0,
    SEQ_BOOT     = 2'd1,
    SEQ_PWRT     = 2'd2,
    SEQ_RUN      = 2'd3
  } seq_state_e;

  localparam logic [1:0] BOR_CFG_ON = 2'b00;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= {STAGES{RST_VAL}};
    else          chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_bor_filter.sv
module rstseq_bor_filter
  import rstseq_pkg::*;
#(
  parameter int TBOR_CYC = 100
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       low_s_i,
  input  logic [1:0] cfg_i,
  output logic       trip_o
);
  localparam int CW = $clog2(TBOR_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TBOR_CYC);

  logic          enabled;
  logic [CW-1:0] run_q;

  assign enabled = (cfg_i == BOR_CFG_ON);

  // counts consecutive low cycles, saturating at the threshold
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      run_q <= '0;
    end else if (low_s_i && enabled) begin
      if (run_q != LIMIT) run_q <= run_q + CW'(1);
    end else begin
      run_q <= '0;
    end
  end

  assign trip_o = enabled && (run_q == LIMIT);
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int POR_CYC  = 200000,
  parameter int PWRT_CYC = 3200000
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       bor_trip_i,
  input  logic       illegal_i,
  input  logic       boot_done_i,
  input  logic       pwrt_en_i,
  output seq_state_e state_o,
  output logic       boot_en_o
);
  localparam int TMAX = (POR_CYC > PWRT_CYC) ? POR_CYC : PWRT_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] POR_LAST  = TW'(POR_CYC - 1);
  localparam logic [TW-1:0] PWRT_LAST = TW'(PWRT_CYC - 1);

  seq_state_e    state_q, state_n;
  logic [TW-1:0] tmr_q, tmr_n;
  logic          restart;

  assign restart = bor_trip_i || (illegal_i && (state_q == SEQ_RUN));

  always_comb begin
    state_n = state_q;
    tmr_n   = tmr_q;
    unique case (state_q)
      SEQ_POR_WAIT: begin
        if (bor_trip_i) begin
          tmr_n = '0;
        end else if (tmr_q == POR_LAST) begin
          state_n = SEQ_BOOT;
          tmr_n   = '0;
        end else begin
          tmr_n = tmr_q + TW'(1);
        end
      end
      SEQ_BOOT: begin
        tmr_n = '0;
        if (!bor_trip_i && boot_done_i) state_n = pwrt_en_i ? SEQ_PWRT : SEQ_RUN;
      end
      SEQ_PWRT: begin
        if (restart) begin
          tmr_n = '0;
        end else if (!pwrt_en_i || (tmr_q == PWRT_LAST)) begin
          state_n = SEQ_RUN;
          tmr_n   = '0;
        end else begin
          tmr_n = tmr_q + TW'(1);
        end
      end
      SEQ_RUN: begin
        if (restart) begin
          state_n = SEQ_PWRT;
          tmr_n   = '0;
        end
      end
      default: begin
        state_n = SEQ_POR_WAIT;
        tmr_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= SEQ_POR_WAIT;
      tmr_q   <= '0;
    end else begin
      state_q <= state_n;
      tmr_q   <= tmr_n;
    end
  end

  assign state_o   = state_q;
  assign boot_en_o = (state_q == SEQ_BOOT);
endmodule

// File: rtl/rstseq_pcon.sv
module rstseq_pcon (
  input  logic       clk_i,
  input  logic       por_n_i,
  input  logic       bor_trip_i,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  output logic [1:0] flags_o
);
  logic por_flag_q;
  logic bor_flag_q;

  // power-on flag: cleared by power-on only, set by writing 1
  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i)                por_flag_q <= 1'b0;
    else if (wr_i && wdata_i[1]) por_flag_q <= 1'b1;
  end

  // brown-out flag: no reset term, so power-on leaves it as it was
  always_ff @(posedge clk_i) begin
    if (bor_trip_i)              bor_flag_q <= 1'b0;
    else if (wr_i && wdata_i[0]) bor_flag_q <= 1'b1;
  end

  assign flags_o = {por_flag_q, bor_flag_q};
endmodule

// File: rtl/mcu_reset_seq.sv
module mcu_reset_seq
  import rstseq_pkg::*;
#(
  parameter int POR_CYC   = 200000,
  parameter int PWRT_CYC  = 3200000,
  parameter int TBOR_CYC  = 100,
  parameter int SYNC_STG  = 2
) (
  input  logic       clk_i,
  input  logic       por_n_i,
  input  logic       bor_low_i,
  input  logic [1:0] bor_cfg_i,
  input  logic       ext_rst_n_i,
  input  logic       illegal_op_i,
  input  logic       boot_done_i,
  input  logic       pwrt_en_i,
  input  logic       pcon_wr_i,
  input  logic [1:0] pcon_wdata_i,
  output logic [1:0] pcon_rdata_o,
  output logic       boot_en_o,
  output logic [1:0] state_o,
  output logic       sys_rst_n_o
);
  logic       ext_s;
  logic       low_s;
  logic       bor_trip;
  seq_state_e seq_state;

  rstseq_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_ext_sync (
    .clk_i(clk_i), .rst_n_i(por_n_i), .d_i(ext_rst_n_i), .q_o(ext_s)
  );

  rstseq_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_bor_sync (
    .clk_i(clk_i), .rst_n_i(por_n_i), .d_i(bor_low_i), .q_o(low_s)
  );

  rstseq_bor_filter #(.TBOR_CYC(TBOR_CYC)) u_bor_filt (
    .clk_i(clk_i), .rst_n_i(por_n_i), .low_s_i(low_s),
    .cfg_i(bor_cfg_i), .trip_o(bor_trip)
  );

  rstseq_fsm #(.POR_CYC(POR_CYC), .PWRT_CYC(PWRT_CYC)) u_fsm (
    .clk_i(clk_i), .rst_n_i(por_n_i), .bor_trip_i(bor_trip),
    .illegal_i(illegal_op_i), .boot_done_i(boot_done_i),
    .pwrt_en_i(pwrt_en_i), .state_o(seq_state), .boot_en_o(boot_en_o)
  );

  rstseq_pcon u_pcon (
    .clk_i(clk_i), .por_n_i(por_n_i), .bor_trip_i(bor_trip),
    .wr_i(pcon_wr_i), .wdata_i(pcon_wdata_i), .flags_o(pcon_rdata_o)
  );

  assign state_o     = seq_state;
  // release only from run; any live source pulls reset low at once
  assign sys_rst_n_o = (seq_state == SEQ_RUN) && ext_s && !bor_trip && !illegal_op_i;
endmodule

// File: rtl/mcu_reset_seq_chk.sv
module mcu_reset_seq_chk #(
  parameter int POR_CYC  = 200000,
  parameter int PWRT_CYC = 3200000
) (
  input logic       clk_i,
  input logic       por_n_i,
  input logic       illegal_op_i,
  input logic       pwrt_en_i,
  input logic       pcon_wr_i,
  input logic [1:0] pcon_wdata_i,
  input logic [1:0] pcon_rdata_o,
  input logic       boot_en_o,
  input logic [1:0] state_o,
  input logic       sys_rst_n_o
);
  logic [31:0] por_cnt;
  logic [31:0] pw_cnt;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      por_cnt <= '0;
      pw_cnt  <= '0;
    end else begin
      if (state_o == 2'd0 && por_cnt != 32'hFFFF_FFFF) por_cnt <= por_cnt + 32'd1;
      if (state_o == 2'd2) begin
        if (pw_cnt != 32'hFFFF_FFFF) pw_cnt <= pw_cnt + 32'd1;
      end else begin
        pw_cnt <= '0;
      end
    end
  end

  assert_rst_only_in_run_R11: assert property (@(posedge clk_i) disable iff (!por_n_i)
    sys_rst_n_o |-> (state_o == 2'd3));

  assert_boot_after_wait_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $rose(boot_en_o) |-> ($past(state_o) == 2'd0));

  assert_wait_length_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
    ($past(state_o) == 2'd0 && state_o == 2'd1) |-> (por_cnt >= 32'(POR_CYC)));

  assert_timer_length_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
    ($past(state_o) == 2'd2 && state_o == 2'd3 && $past(pwrt_en_i)) |-> (pw_cnt >= 32'(PWRT_CYC)));

  assert_illegal_restart_R4: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (state_o == 2'd3 && illegal_op_i && pwrt_en_i) |=> (state_o == 2'd2));

  assert_por_flag_set_R8: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $rose(pcon_rdata_o[1]) |-> $past(pcon_wr_i && pcon_wdata_i[1]));
endmodule

bind mcu_reset_seq mcu_reset_seq_chk #(.POR_CYC(POR_CYC), .PWRT_CYC(PWRT_CYC)) u_chk (
  .clk_i(clk_i), .por_n_i(por_n_i), .illegal_op_i(illegal_op_i),
  .pwrt_en_i(pwrt_en_i), .pcon_wr_i(pcon_wr_i), .pcon_wdata_i(pcon_wdata_i),
  .pcon_rdata_o(pcon_rdata_o), .boot_en_o(boot_en_o), .state_o(state_o),
  .sys_rst_n_o(sys_rst_n_o)
);

// File: tb/mcu_reset_seq_test.sv
`timescale 1ns/1ps
module mcu_reset_seq_test;
  localparam int POR_C  = 40;
  localparam int PWRT_C = 64;
  localparam int TBOR_C = 6;

  logic       clk = 1'b0;
  logic       por_n, bor_low, ext_n, illegal, boot_done, pwrt_en, wr;
  logic [1:0] cfg, wdata, rdata, state;
  logic       boot_en, sys_rst_n;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mcu_reset_seq #(.POR_CYC(POR_C), .PWRT_CYC(PWRT_C), .TBOR_CYC(TBOR_C)) uut (
    .clk_i(clk), .por_n_i(por_n), .bor_low_i(bor_low), .bor_cfg_i(cfg),
    .ext_rst_n_i(ext_n), .illegal_op_i(illegal), .boot_done_i(boot_done),
    .pwrt_en_i(pwrt_en), .pcon_wr_i(wr), .pcon_wdata_i(wdata),
    .pcon_rdata_o(rdata), .boot_en_o(boot_en), .state_o(state),
    .sys_rst_n_o(sys_rst_n)
  );

  function automatic bit exp_trip(input logic [1:0] c, input int len);
    return (c == 2'b00) && (len >= TBOR_C);
  endfunction

  function automatic int exp_last_low();
    return PWRT_C + 2;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_state(input logic [1:0] tgt, output int cnt);
    cnt = 0;
    while (state != tgt && cnt < 5000) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic pcon_write(input logic [1:0] d);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = 2'b00;
  endtask

  task automatic bor_pulse(input logic [1:0] c, input int len, input string req);
    bit seen_low;
    int last_low;
    bit e;
    e = exp_trip(c, len);
    seen_low = 0; last_low = 0;
    cfg = c;
    bor_low = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (!sys_rst_n) seen_low = 1;
    end
    bor_low = 1'b0;
    for (int k = 1; k <= PWRT_C + 8; k++) begin
      @(negedge clk);
      if (!sys_rst_n) begin seen_low = 1; last_low = k; end
    end
    cfg = 2'b00;
    chk(seen_low == e, req, "reset seen", seen_low, e);
    if (e) chk(last_low == exp_last_low(), req, "last low cycle after release", last_low, exp_last_low());
    chk(rdata[0] == !e, "R9", "brown-out flag", rdata[0], !e);
    chk(state == 2'd3 && sys_rst_n, req, "back in run", state, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5eed));
    por_n = 0; bor_low = 0; ext_n = 1; illegal = 0; boot_done = 0;
    pwrt_en = 1; wr = 0; cfg = 2'b00; wdata = 2'b00;
    repeat (5) @(negedge clk);
    chk(sys_rst_n == 0, "R11", "reset held in power-on", sys_rst_n, 0);
    chk(state == 2'd0, "R11", "power-on state code", state, 0);
    chk(rdata[1] == 0, "R8", "power-on flag at power-on", rdata[1], 0);

    por_n = 1;
    wait_state(2'd1, n);
    chk(n == POR_C, "R5", "start-up wait cycles", n, POR_C);
    chk(boot_en == 1 && sys_rst_n == 0, "R5", "boot enable in boot", boot_en, 1);
    n = 3 + int'($urandom % 8);
    repeat (n) @(negedge clk);
    chk(state == 2'd1, "R5", "boot waits for done", state, 1);
    boot_done = 1;
    @(negedge clk);
    boot_done = 0;
    chk(state == 2'd2 && sys_rst_n == 0, "R6", "timer state after boot", state, 2);
    wait_state(2'd3, n);
    chk(n == PWRT_C, "R6", "timer cycles", n, PWRT_C);
    chk(sys_rst_n == 1, "R11", "released in run", sys_rst_n, 1);

    pcon_write(2'b11);
    chk(rdata == 2'b11, "R8", "flags after writing ones", rdata, 3);
    pcon_write(2'b00);
    chk(rdata == 2'b11, "R10", "writing zeros ignored", rdata, 3);

    ext_n = 0;
    @(negedge clk);
    chk(sys_rst_n == 1, "R7", "pin after one edge", sys_rst_n, 1);
    @(negedge clk);
    chk(sys_rst_n == 0, "R7", "pin after two edges", sys_rst_n, 0);
    repeat (5 + int'($urandom % 16)) @(negedge clk);
    chk(state == 2'd3 && sys_rst_n == 0, "R7", "run held by pin", state, 3);
    ext_n = 1;
    repeat (2) @(negedge clk);
    chk(sys_rst_n == 1, "R7", "immediate release", sys_rst_n, 1);
    chk(rdata == 2'b11, "R9", "flags kept across pin reset", rdata, 3);

    bor_pulse(2'b00, TBOR_C - 1, "R2");
    bor_pulse(2'b00, TBOR_C, "R3");
    pcon_write(2'b11);
    bor_pulse(2'b01, TBOR_C + 4, "R1");
    bor_pulse(2'b10 | 2'($urandom % 2), TBOR_C + 9, "R1");

    @(negedge clk);
    illegal = 1;
    #1;
    chk(sys_rst_n == 0, "R4", "same-cycle opcode reset", sys_rst_n, 0);
    @(negedge clk);
    illegal = 0;
    chk(state == 2'd2, "R4", "timer after opcode", state, 2);
    wait_state(2'd3, n);
    chk(n == PWRT_C, "R6", "timer after opcode", n, PWRT_C);
    chk(rdata == 2'b11, "R4", "flags kept across opcode reset", rdata, 3);

    pwrt_en = 0;
    @(negedge clk);
    illegal = 1;
    @(negedge clk);
    illegal = 0;
    wait_state(2'd3, n);
    chk(n == 1, "R6", "single timer cycle when disabled", n, 1);

    por_n = 0;
    repeat (3) @(negedge clk);
    chk(rdata == 2'b01, "R9", "power-on keeps brown-out flag", rdata, 1);
    por_n = 1;
    wait_state(2'd1, n);
    chk(n == POR_C, "R5", "second start-up wait", n, POR_C);
    boot_done = 1;
    @(negedge clk);
    boot_done = 0;
    chk(state == 2'd3 && sys_rst_n == 1, "R6", "boot straight to run", state, 3);
    chk(rdata[1] == 0, "R8", "power-on flag after second power-on", rdata[1], 0);
    pwrt_en = 1;
    @(negedge clk);

    for (int it = 0; it < 10; it++) begin
      logic [1:0] c;
      int len;
      pcon_write(2'b11);
      c   = ($urandom % 2 == 0) ? 2'b00 : 2'($urandom % 4);
      len = 1 + int'($urandom % (2 * TBOR_C));
      bor_pulse(c, len, exp_trip(c, len) ? "R3" : (c == 2'b00 ? "R2" : "R1"));
      chk(rdata[1] == 1, "R8", "power-on flag untouched by brown-out", rdata[1], 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule